// File: doc/BRIEF.md
# Arithmetic Logic Unit with Sign, Zero, Carry and Overflow Flags

This block is a width-parameterised arithmetic logic unit. It takes two operands and a 3-bit operation code. It returns a result word together with four status bits: negative, zero, carry and overflow. The operations are bitwise AND, bitwise XOR, addition, subtraction and decrement. The operands are treated as plain bit patterns. Both the unsigned indicator (carry) and the signed indicator (overflow) come out on every arithmetic operation, and the consumer chooses which one applies to its data.

A single adder serves addition, subtraction and decrement. Subtraction adds the inverted subtrahend and a carry-in of one. As a result, the carry bit on subtraction reports "no borrow" rather than "borrow". Results stay in two's complement form.

The datapath is combinational. A parameter adds an output register stage, which is enabled by default and gives one cycle of latency.

Top module: `alu_nzcv_core`

## Requirements
- R1: Opcode 3'b000 yields the bitwise AND of the operands.
- R2: Opcode 3'b001 yields the bitwise XOR of the operands.
- R3: Opcode 3'b010 yields A+B modulo 2^WIDTH, with carry equal to the carry out of the top bit (1 when the unsigned sum exceeds 2^WIDTH-1).
- R4: Opcode 3'b011 yields A-B modulo 2^WIDTH, with carry 1 exactly when A >= B as unsigned values (carry = not borrow).
- R5: On opcodes 010, 011 and 100, overflow is 1 exactly when the true signed result lies outside -2^(WIDTH-1) .. 2^(WIDTH-1)-1.
- R6: Opcode 3'b100 yields A-1 and ignores B. Carry is 0 only when A is 0, and overflow is 1 only when A is the most negative value.
- R7: For opcodes 000 to 100, negative equals the top result bit and zero is 1 exactly when every result bit is 0.
- R8: For opcodes 000 and 001, carry and overflow are 0.
- R9: Opcodes 101, 110 and 111 give a zero result with negative, zero, carry and overflow all 0.
- R10: With the output stage enabled, results and flags appear one clock edge after the operands are sampled. Reset (active low, asynchronous) sets the result to 0, zero to 1, and the other flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output stage |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | WIDTH | First operand (minuend) |
| op_b_i | input | WIDTH | Second operand (subtrahend) |
| opcode_i | input | 3 | Operation select |
| result_o | output | WIDTH | Operation result |
| flag_n_o | output | 1 | Negative: top result bit |
| flag_z_o | output | 1 | Zero: result is all zeros |
| flag_c_o | output | 1 | Carry out / not-borrow |
| flag_v_o | output | 1 | Signed overflow |

## Verification
Every result and all four flags are due exactly one rising edge after the operands and opcode are presented. No output takes longer.

The bench changes inputs on the falling edge. It reads the outputs on the next falling edge, which lies after the single capturing rising edge. A separate probe reads the outputs shortly after new inputs are applied, before any rising edge, and expects the previous result there. An asynchronous reset probe is read a fraction of a cycle after reset falls, with no clock edge in between.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_XOR = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b011,
        OP_DEC = 3'b100
    } alu_op_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } alu_flags_t;

endpackage

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sel_xor_i,
    output logic [WIDTH-1:0] y_o
);
    always_comb begin
        if (sel_xor_i) y_o = a_i ^ b_i;
        else           y_o = a_i & b_i;
    end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int LOW_W = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] low_sum;
    logic             c_into_top;
    logic [1:0]       top_sum;

    always_comb begin
        b_eff      = sub_i ? ~b_i : b_i;
        // lower bits with one spare bit to capture the carry into the top bit
        low_sum    = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]}
                   + {{LOW_W{1'b0}}, sub_i};
        c_into_top = low_sum[LOW_W];
        top_sum    = {1'b0, a_i[WIDTH-1]} + {1'b0, b_eff[WIDTH-1]}
                   + {1'b0, c_into_top};
        sum_o      = {top_sum[0], low_sum[LOW_W-1:0]};
        carry_o    = top_sum[1];
        ovf_o      = top_sum[1] ^ c_into_top;
    end
endmodule

// File: rtl/alu_nzcv_core.sv
module alu_nzcv_core
    import alu_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    input  logic [2:0]       opcode_i,
    output logic [WIDTH-1:0] result_o,
    output logic             flag_n_o,
    output logic             flag_z_o,
    output logic             flag_c_o,
    output logic             flag_v_o
);
    localparam int MSB = WIDTH - 1;
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] res;
        alu_flags_t       flg;
    } stage_t;

    localparam stage_t RESET_STAGE = '{res: '0, flg: '{neg: 1'b0, zero: 1'b1, carry: 1'b0, ovf: 1'b0}};

    logic [WIDTH-1:0] bit_y;
    logic [WIDTH-1:0] add_b;
    logic             add_sub;
    logic [WIDTH-1:0] add_sum;
    logic             add_c;
    logic             add_v;
    stage_t           stage_d;
    stage_t           stage_q;

    alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a_i       (op_a_i),
        .b_i       (op_b_i),
        .sel_xor_i (opcode_i == OP_XOR),
        .y_o       (bit_y)
    );

    always_comb begin
        add_sub = (opcode_i == OP_SUB) || (opcode_i == OP_DEC);
        add_b   = (opcode_i == OP_DEC) ? ONE : op_b_i;
    end

    alu_adder #(.WIDTH(WIDTH)) u_adder (
        .a_i     (op_a_i),
        .b_i     (add_b),
        .sub_i   (add_sub),
        .sum_o   (add_sum),
        .carry_o (add_c),
        .ovf_o   (add_v)
    );

    always_comb begin
        stage_d = '0;
        case (opcode_i)
            OP_AND, OP_XOR: begin
                stage_d.res       = bit_y;
                stage_d.flg.neg   = bit_y[MSB];
                stage_d.flg.zero  = (bit_y == '0);
            end
            OP_ADD, OP_SUB, OP_DEC: begin
                stage_d.res       = add_sum;
                stage_d.flg.neg   = add_sum[MSB];
                stage_d.flg.zero  = (add_sum == '0);
                stage_d.flg.carry = add_c;
                stage_d.flg.ovf   = add_v;
            end
            default: stage_d = '0;
        endcase
    end

    generate
        if (OUT_REG) begin : g_reg
            logic past_ok_q;

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    stage_q   <= RESET_STAGE;
                    past_ok_q <= 1'b0;
                end else begin
                    stage_q   <= stage_d;
                    past_ok_q <= 1'b1;
                end
            end

            p_logic_cv_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (past_ok_q && ($past(opcode_i) == OP_AND || $past(opcode_i) == OP_XOR))
                |-> (!flag_c_o && !flag_v_o));

            p_bad_op_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (past_ok_q && $past(opcode_i) > OP_DEC)
                |-> (result_o == '0 && !flag_n_o && !flag_z_o && !flag_c_o && !flag_v_o));

            p_sub_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (past_ok_q && $past(opcode_i) == OP_SUB)
                |-> (flag_c_o == ($past(op_a_i) >= $past(op_b_i))));

            p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (past_ok_q && $past(opcode_i) == OP_ADD
                 && ($past(op_a_i[MSB]) != $past(op_b_i[MSB])))
                |-> !flag_v_o);

            p_dec_carry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (past_ok_q && $past(opcode_i) == OP_DEC)
                |-> (flag_c_o == ($past(op_a_i) != '0)));

            p_zero_seen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (past_ok_q && $past(opcode_i) <= OP_DEC && result_o == '0)
                |-> flag_z_o);
        end else begin : g_comb
            always_comb stage_q = stage_d;
        end
    endgenerate

    assign result_o = stage_q.res;
    assign flag_n_o = stage_q.flg.neg;
    assign flag_z_o = stage_q.flg.zero;
    assign flag_c_o = stage_q.flg.carry;
    assign flag_v_o = stage_q.flg.ovf;

    p_neg_is_top_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_n_o == result_o[MSB]);

    p_zero_implies_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flag_z_o |-> (result_o == '0));

endmodule

// File: tb/alu_nzcv_core_tb.sv
`timescale 1ns/1ps
module alu_nzcv_core_tb_top;
    localparam int W = 8;
    localparam int NV = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [2:0]   op = 3'b000;
    logic [W-1:0] res;
    logic         fn, fz, fc, fv;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    alu_nzcv_core #(.WIDTH(W), .OUT_REG(1'b1)) dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .op_a_i   (a),
        .op_b_i   (b),
        .opcode_i (op),
        .result_o (res),
        .flag_n_o (fn),
        .flag_z_o (fz),
        .flag_c_o (fc),
        .flag_v_o (fv)
    );

    // {opcode, a, b, expected result, expected {n,z,c,v}}
    localparam logic [30:0] VECS [NV] = '{
        {3'd0, 8'hF0, 8'h3C, 8'h30, 4'b0000},
        {3'd0, 8'h0F, 8'hF0, 8'h00, 4'b0100},
        {3'd1, 8'hA5, 8'h5A, 8'hFF, 4'b1000},
        {3'd1, 8'h77, 8'h77, 8'h00, 4'b0100},
        {3'd2, 8'h07, 8'h04, 8'h0B, 4'b0000},
        {3'd2, 8'hFF, 8'h01, 8'h00, 4'b0110},
        {3'd2, 8'h7F, 8'h01, 8'h80, 4'b1001},
        {3'd2, 8'h80, 8'h80, 8'h00, 4'b0111},
        {3'd3, 8'h09, 8'h04, 8'h05, 4'b0010},
        {3'd3, 8'h04, 8'h09, 8'hFB, 4'b1000},
        {3'd3, 8'h80, 8'h01, 8'h7F, 4'b0011},
        {3'd3, 8'h05, 8'h05, 8'h00, 4'b0110},
        {3'd3, 8'h7F, 8'hFF, 8'h80, 4'b1001},
        {3'd4, 8'h00, 8'h00, 8'hFF, 4'b1000},
        {3'd4, 8'h01, 8'h00, 8'h00, 4'b0110},
        {3'd4, 8'h80, 8'h00, 8'h7F, 4'b0011},
        {3'd5, 8'h12, 8'h34, 8'h00, 4'b0000},
        {3'd7, 8'hFF, 8'hFF, 8'h00, 4'b0000},
        {3'd4, 8'h10, 8'hFF, 8'h0F, 4'b0010},
        {3'd0, 8'hFF, 8'hFF, 8'hFF, 4'b1000}
    };

    task automatic check_out(input string req, input logic [W-1:0] eres, input logic [3:0] eflg);
        checks++;
        if (res !== eres || {fn, fz, fc, fv} !== eflg) begin
            fails++;
            $display("FAIL %s: got res=%h nzcv=%b, expected res=%h nzcv=%b",
                     req, res, {fn, fz, fc, fv}, eres, eflg);
        end
    endtask

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'd0: return "R1 R7 R8";
            3'd1: return "R2 R7 R8";
            3'd2: return "R3 R5 R7";
            3'd3: return "R4 R5 R7";
            3'd4: return "R6 R5 R7";
            default: return "R9";
        endcase
    endfunction

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL R10: watchdog expired, got no completion, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_out("R10 reset", 8'h00, 4'b0100);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R10 reset hold", 8'h00, 4'b0100);

        for (int i = 0; i < NV; i++) begin
            op = VECS[i][30:28];
            a  = VECS[i][27:20];
            b  = VECS[i][19:12];
            @(negedge clk);
            check_out(req_of(op), VECS[i][11:4], VECS[i][3:0]);
        end

        // R10 latency: new inputs must not show before a rising edge
        op = 3'd2; a = 8'h01; b = 8'h01;
        #1;
        check_out("R10 before edge", 8'hFF, 4'b1000);
        @(negedge clk);
        check_out("R10 after edge R3", 8'h02, 4'b0000);

        // R6: B has no effect on decrement
        op = 3'd4; a = 8'h00; b = 8'h5C;
        @(negedge clk);
        check_out("R6 zero operand", 8'hFF, 4'b1000);

        // R10: asynchronous reset mid-run
        op = 3'd2; a = 8'h7F; b = 8'h01;
        @(negedge clk);
        check_out("R5 pre-reset", 8'h80, 4'b1001);
        rst_n = 1'b0;
        #1;
        check_out("R10 async reset", 8'h00, 4'b0100);
        @(negedge clk);
        rst_n = 1'b1;
        op = 3'd6; a = 8'hAA; b = 8'h55;
        @(negedge clk);
        check_out("R9 after reset", 8'h00, 4'b0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule